// File: doc/BRIEF.md
# Processor-Hot Throttle Pulse Controller

This block watches twelve digital over-power event flags and turns them into one active-low throttle request for a host processor. The flags are adapter peak current, adapter average current, two battery discharge levels, system voltage, bus voltage in battery-assist mode, adapter removal, battery removal, comparator trip, input-voltage limit and thermal. The exit from battery-assist mode is the twelfth flag. Each flag arrives already compared. It passes through an assertion-side deglitch filter that counts `tick_i` pulses, and then through an enable.

The throttle output is pulled low for a programmable minimum number of ticks. It stays low while any enabled event is still active. When extension mode is on, it also stays low until the host clears it. Two events, the input-voltage limit and the exit from battery assist, hold the output low until the host writes 0 to the status bit of that event. Status latches record each event. The latches clear in one of three ways. Level bits set again at once if their event is still present. The battery-removal bit is edge-only. The thermal bit latches once its long deglitch completes.

Software reaches the block through a four-register write port and a read strobe. The input-voltage-limit flag is chosen from three comparator flags by two control bits.

Top module: `pwr_throttle_ctl`

## Requirements
- R1: After `rst_n` low, `throttle_n_o` is 1 and the enable, control, deglitch and status registers all read 0.
- R2: An enabled event that passes its filter drives `throttle_n_o` low for at least W clocks, with `tick_i` held high. W = PW_BASE << pw, where pw is CTRL[1:0]. A one-clock event with no deglitch gives a low pulse of exactly W clocks.
- R3: While an enabled filtered event stays active past W, the output stays low. It returns high one clock after the filtered event drops. A raw event of L clocks with no deglitch gives max(L, W) low clocks.
- R4: With CTRL[2] (extend) set, the output stays low after the event ends. It releases only after a write to CTRL with bit 6 (host clear) set.
- R5: Status bit 11 (input-voltage limit) and status bit 9 (exit-assist) hold the output low in either mode. Each holds until a write to STAT (address 3) carries 0 in that bit.
- R6: ENA (address 0) bit i enables event i. A disabled event neither moves the output nor sets status. Event 9 (exit-assist) acts even with ENA bit 9 at 0.
- R7: Status bits other than 9 and 11 clear when STAT is read with `rd_en_i`. The adapter-removal bit 6 sets again at once while its filtered input is still high.
- R8: Battery-removal status bit 7 sets only on a rising edge of its filtered input. After a read clears it, it stays 0 while the input remains high.
- R9: The thermal event (bit 10) must be high for THERM_SHORT ticks when CTRL[5]=0, or THERM_LONG ticks when CTRL[5]=1, before status bit 10 sets. It then stays latched after the input drops.
- R10: The input-voltage-limit event is taken from `vlim_cmp_i`. With CTRL[3]=0 it uses bit 0 (below 100 %). With CTRL[3]=1 it uses bit 2 (below 83 %) when CTRL[4]=0, and bit 1 (below 91 %) when CTRL[4]=1.
- R11: Events 0, 1, 2, 3 and 8 need a deglitch of code×DG_STEP ticks. Their 2-bit codes sit in DGL (address 2) at [1:0], [3:2], [5:4], [7:6] and [9:8]. Events 6 and 7 use REM_TICKS. All others pass with no deglitch. A raw pulse no longer than the deglitch count has no effect.
- R12: A write to CTRL with bit 7 set clears every status latch, the extension hold and the pulse timer. It drives the output high on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Time-base pulse for deglitch and pulse-width counting |
| evt_i | input | 11 | Raw event flags, index 0..10 as listed in R6 to R11, active high |
| vlim_cmp_i | input | 3 | Input-voltage comparators: [0] below 100 %, [1] below 91 %, [2] below 83 % |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears STAT bits on read) |
| addr_i | input | 2 | Register address: 0 ENA, 1 CTRL, 2 DGL, 3 STAT |
| wr_data_i | input | 12 | Write data |
| rd_data_o | output | 12 | Read data of the addressed register, combinational |
| throttle_n_o | output | 1 | Active-low throttle request, registered |

## Verification
A filter counter that is off by one tick moves the point where the output falls by that same amount. A wrong minimum-width load does the same to the end of the pulse. So the bench counts low clocks exactly over a window, and a single-cycle error shows up within tens of clocks. A status latch with the wrong clear rule only shows at the next STAT read, as a bit that is present or missing. A stuck hold latch shows as an output that fails to rise two clocks after the host clear or status write.

// File: rtl/ptc_pkg.sv
// Shared constants for the throttle pulse controller: event indices,
// register addresses and control-bit positions.
package ptc_pkg;
    localparam int NUM_EV  = 12;
    localparam int NUM_RAW = 11;
    localparam int DW      = 12;

    localparam int EV_ADPK  = 0;
    localparam int EV_ADAVG = 1;
    localparam int EV_DIS1  = 2;
    localparam int EV_DIS2  = 3;
    localparam int EV_SYSV  = 4;
    localparam int EV_BUSV  = 5;
    localparam int EV_ADRM  = 6;
    localparam int EV_BTRM  = 7;
    localparam int EV_CMP   = 8;
    localparam int EV_XASST = 9;
    localparam int EV_THERM = 10;
    localparam int EV_VLIM  = 11;

    typedef enum logic [1:0] {
        A_ENA  = 2'd0,
        A_CTRL = 2'd1,
        A_DGL  = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    localparam int C_PW    = 0;
    localparam int C_EXT   = 2;
    localparam int C_LOWER = 3;
    localparam int C_SEL91 = 4;
    localparam int C_TLONG = 5;
    localparam int C_HCLR  = 6;
    localparam int C_SRST  = 7;

    localparam logic [NUM_EV-1:0] HOLD_MASK =
        NUM_EV'((1 << EV_XASST) | (1 << EV_VLIM));
endpackage

// File: rtl/ptc_deglitch.sv
// Assertion-side deglitch filter. The output rises once the raw flag has
// been high for thr_i ticks and falls on the clock after the raw flag drops.
// Assumes thr_i is stable while the raw flag is high.
module ptc_deglitch #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             filt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             filt_q;

    // Count ticks while raw is high; qualify when the threshold is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (!raw_i) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (!filt_q) begin
            if (cnt_q >= thr_i) filt_q <= 1'b1;
            else if (tick_i)    cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign filt_o = filt_q;

    // R11
    release_follows_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(raw_i) |-> !filt_o);
endmodule

// File: rtl/ptc_status.sv
// Status latches. Level bits set every clock their enabled event is active.
// The battery-removal bit sets on a rising edge only. Read clears all
// non-hold bits; hold bits clear through hold_clr_i. A soft reset clears all.
module ptc_status
    import ptc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] act_i,
    input  logic              rd_clr_i,
    input  logic [NUM_EV-1:0] hold_clr_i,
    input  logic              soft_rst_i,
    output logic [NUM_EV-1:0] st_o
);
    logic [NUM_EV-1:0] st_q, act_prev_q, set_v, clr_v;

    // Set sources: levels everywhere except the edge-only battery-removal bit.
    always_comb begin
        set_v          = act_i;
        set_v[EV_BTRM] = act_i[EV_BTRM] & ~act_prev_q[EV_BTRM];
        clr_v          = hold_clr_i | ({NUM_EV{rd_clr_i}} & ~HOLD_MASK);
    end

    // Latch update; a set in the same clock as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            act_prev_q <= '0;
        end else begin
            act_prev_q <= act_i;
            st_q       <= soft_rst_i ? '0 : ((st_q & ~clr_v) | set_v);
        end
    end

    assign st_o = st_q;

    // R8
    btrm_no_level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q[EV_BTRM] && act_i[EV_BTRM] && $past(act_i[EV_BTRM])) |=> !st_q[EV_BTRM]);

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[EV_VLIM] && !hold_clr_i[EV_VLIM] && !soft_rst_i) |=> st_q[EV_VLIM]);
endmodule

// File: rtl/ptc_pulse.sv
// Throttle output sequencer. A new enabled event loads a minimum-width timer.
// The registered active-low output stays low while the timer runs, any event
// is active, the extension latch is set or a hold status is present.
module ptc_pulse #(
    parameter int NUM_EV  = 12,
    parameter int PW_BASE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [NUM_EV-1:0] act_i,
    input  logic              hold_i,
    input  logic              ext_en_i,
    input  logic              host_clr_i,
    input  logic              soft_rst_i,
    input  logic [1:0]        pw_code_i,
    output logic              throttle_n_o
);
    localparam int PW_MAX = PW_BASE * 8;
    localparam int PW_W   = $clog2(PW_MAX + 1);

    logic [NUM_EV-1:0] act_prev_q;
    logic [PW_W-1:0]   cnt_q, pw_load;
    logic              ext_q, out_n_q, act_any, trig, low_nx;

    assign pw_load = PW_W'((PW_BASE << pw_code_i) - 1);
    assign act_any = |act_i;
    assign trig    = |(act_i & ~act_prev_q);
    assign low_nx  = trig | (cnt_q != '0) | act_any | ext_q | hold_i;

    // Remember the event vector to spot newly arriving events.
    always_ff @(posedge clk) begin
        if (!rst_n) act_prev_q <= '0;
        else        act_prev_q <= act_i;
    end

    // Minimum-width timer: load on a new event, count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i)         cnt_q <= '0;
        else if (trig)                    cnt_q <= pw_load;
        else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // Extension latch: set by a new event in extend mode, cleared by host.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i)         ext_q <= 1'b0;
        else if (trig && ext_en_i)        ext_q <= 1'b1;
        else if (host_clr_i)              ext_q <= 1'b0;
    end

    // Registered, glitch-free active-low output.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst_i) out_n_q <= 1'b1;
        else                      out_n_q <= ~low_nx;
    end

    assign throttle_n_o = out_n_q;

    // R2
    fall_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle_n_o) |-> $past(act_any || hold_i));

    // R3
    active_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_any && !soft_rst_i) |=> !throttle_n_o);

    // R12
    soft_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> throttle_n_o);

    // R4
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_q && !host_clr_i && !soft_rst_i) |=> !throttle_n_o);
endmodule

// File: rtl/pwr_throttle_ctl.sv
// Top of the throttle pulse controller: register file, input-voltage-limit
// threshold select, per-event deglitch filters, status latches and output
// sequencer. Assumes event flags are synchronous to clk.
module pwr_throttle_ctl
    import ptc_pkg::*;
#(
    parameter int PW_BASE     = 4,
    parameter int DG_STEP     = 4,
    parameter int REM_TICKS   = 1,
    parameter int THERM_SHORT = 100,
    parameter int THERM_LONG  = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [NUM_RAW-1:0] evt_i,
    input  logic [2:0]         vlim_cmp_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [1:0]         addr_i,
    input  logic [DW-1:0]      wr_data_i,
    output logic [DW-1:0]      rd_data_o,
    output logic               throttle_n_o
);
    localparam int M1     = (DG_STEP * 3 > REM_TICKS) ? DG_STEP * 3 : REM_TICKS;
    localparam int M2     = (THERM_LONG > THERM_SHORT) ? THERM_LONG : THERM_SHORT;
    localparam int DG_MAX = (M1 > M2) ? M1 : M2;
    localparam int DG_W   = $clog2(DG_MAX + 1);

    logic [NUM_EV-1:0] ena_q, ena_eff, raw, flt, act, st, hold_clr;
    logic [5:0]        ctrl_q;
    logic [9:0]        dgl_q;
    logic              vlim_sel, host_clr, soft_rst, stat_rd, stat_wr;

    assign host_clr = wr_en_i && (addr_i == A_CTRL) && wr_data_i[C_HCLR];
    assign soft_rst = wr_en_i && (addr_i == A_CTRL) && wr_data_i[C_SRST];
    assign stat_rd  = rd_en_i && (addr_i == A_STAT);
    assign stat_wr  = wr_en_i && (addr_i == A_STAT);
    assign hold_clr = {NUM_EV{stat_wr}} & HOLD_MASK & ~wr_data_i;

    // Configuration registers: written by address, untouched by soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q  <= '0;
            ctrl_q <= '0;
            dgl_q  <= '0;
        end else if (wr_en_i) begin
            case (addr_i)
                A_ENA:   ena_q  <= wr_data_i;
                A_CTRL:  ctrl_q <= wr_data_i[5:0];
                A_DGL:   dgl_q  <= wr_data_i[9:0];
                default: ;
            endcase
        end
    end

    // Read mux of the addressed register.
    always_comb begin
        case (addr_i)
            A_ENA:   rd_data_o = ena_q;
            A_CTRL:  rd_data_o = DW'(ctrl_q);
            A_DGL:   rd_data_o = DW'(dgl_q);
            default: rd_data_o = st;
        endcase
    end

    // Input-voltage-limit comparator chosen by the two threshold bits.
    always_comb begin
        if (!ctrl_q[C_LOWER])     vlim_sel = vlim_cmp_i[0];
        else if (ctrl_q[C_SEL91]) vlim_sel = vlim_cmp_i[1];
        else                      vlim_sel = vlim_cmp_i[2];
    end

    assign raw     = {vlim_sel, evt_i};
    assign ena_eff = ena_q | NUM_EV'(1 << EV_XASST);
    assign act     = flt & ena_eff;

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        logic [DG_W-1:0] thr;
        if (i == EV_ADPK || i == EV_ADAVG || i == EV_DIS1 || i == EV_DIS2 || i == EV_CMP) begin : g_prog
            localparam int SLOT = (i == EV_CMP) ? 4 : i;
            assign thr = DG_W'(dgl_q[2*SLOT +: 2]) * DG_W'(DG_STEP);
        end else if (i == EV_ADRM || i == EV_BTRM) begin : g_rem
            assign thr = DG_W'(REM_TICKS);
        end else if (i == EV_THERM) begin : g_therm
            assign thr = ctrl_q[C_TLONG] ? DG_W'(THERM_LONG) : DG_W'(THERM_SHORT);
        end else begin : g_none
            assign thr = '0;
        end
        ptc_deglitch #(.CNT_W(DG_W)) u_dg (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .raw_i  (raw[i]),
            .thr_i  (thr),
            .filt_o (flt[i])
        );
    end

    ptc_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_i      (act),
        .rd_clr_i   (stat_rd),
        .hold_clr_i (hold_clr),
        .soft_rst_i (soft_rst),
        .st_o       (st)
    );

    ptc_pulse #(.NUM_EV(NUM_EV), .PW_BASE(PW_BASE)) u_pulse (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .act_i        (act),
        .hold_i       (st[EV_VLIM] | st[EV_XASST]),
        .ext_en_i     (ctrl_q[C_EXT]),
        .host_clr_i   (host_clr),
        .soft_rst_i   (soft_rst),
        .pw_code_i    (ctrl_q[1:0]),
        .throttle_n_o (throttle_n_o)
    );

    // R6
    disabled_no_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ena_q[EV_ADPK] && !st[EV_ADPK]) |=> !st[EV_ADPK]);
endmodule

// File: tb/pwr_throttle_ctl_bench.sv
module pwr_throttle_ctl_bench;
    logic        clk = 0, rst_n = 0, tick = 1;
    logic [10:0] evt = '0;
    logic [2:0]  vcmp = '0;
    logic        wr_en = 0, rd_en = 0;
    logic [1:0]  addr = '0;
    logic [11:0] wdata = '0;
    logic [11:0] rdata;
    logic        thr_n;
    int          n_chk = 0, n_fail = 0;

    pwr_throttle_ctl u_pwr_throttle_ctl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .evt_i(evt), .vlim_cmp_i(vcmp),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wr_data_i(wdata),
        .rd_data_o(rdata), .throttle_n_o(thr_n));

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [11:0] d);
        @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic clear_all();
        logic [11:0] d;
        rd(2'd3, d);
        wr(2'd3, 12'd0);
        idle(2);
    endtask

    // Raise event idx for L clocks and count low output samples over win clocks.
    task automatic pulse_count(input int idx, input int L, input int win, output int n);
        @(negedge clk); evt[idx] = 1; n = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (!thr_n) n++;
            if (k == L - 1) evt[idx] = 0;
        end
    endtask

    task automatic t_reset();
        logic [11:0] d;
        check(thr_n == 1, "R1 out", thr_n, 1);
        rd(2'd3, d); check(d == 0, "R1 stat", d, 0);
        rd(2'd0, d); check(d == 0, "R1 ena", d, 0);
        rd(2'd1, d); check(d == 0, "R1 ctrl", d, 0);
    endtask

    task automatic t_width();
        int n;
        wr(2'd0, 12'h001); wr(2'd1, 12'h000);
        pulse_count(0, 1, 20, n); check(n == 4, "R2 width code0", n, 4);
        clear_all();
        wr(2'd1, 12'h003);
        pulse_count(0, 1, 45, n); check(n == 32, "R2 width code3", n, 32);
        clear_all();
        wr(2'd1, 12'h000);
        pulse_count(0, 20, 40, n); check(n == 20, "R3 stretch", n, 20);
        check(thr_n == 1, "R3 release", thr_n, 1);
        clear_all();
    endtask

    task automatic t_deglitch();
        int n; logic [11:0] d;
        wr(2'd0, 12'h002); wr(2'd2, 12'h008);
        pulse_count(1, 6, 30, n); check(n == 0, "R11 short filtered", n, 0);
        rd(2'd3, d); check(d[1] == 0, "R11 no status", d[1], 0);
        pulse_count(1, 20, 40, n); check(n == 12, "R11 deglitched stretch", n, 12);
        rd(2'd3, d); check(d[1] == 1, "R7 level status", d[1], 1);
        clear_all();
        wr(2'd2, 12'h000);
    endtask

    task automatic t_enable();
        int n; logic [11:0] d;
        wr(2'd0, 12'h000);
        pulse_count(0, 3, 20, n); check(n == 0, "R6 disabled out", n, 0);
        rd(2'd3, d); check(d[0] == 0, "R6 disabled status", d[0], 0);
        @(negedge clk); evt[9] = 1; @(negedge clk); evt[9] = 0;
        idle(30);
        check(thr_n == 0, "R6 exit-assist always on", thr_n, 0);
        rd(2'd3, d); check(d[9] == 1, "R5 exit-assist status", d[9], 1);
        idle(5); check(thr_n == 0, "R5 hold after read", thr_n, 0);
        wr(2'd3, 12'h000); idle(1);
        check(thr_n == 1, "R5 release by write 0", thr_n, 1);
        clear_all();
    endtask

    task automatic t_vlim();
        int n; logic [11:0] d;
        wr(2'd0, 12'h800); wr(2'd1, 12'h008);
        @(negedge clk); vcmp = 3'b011; n = 0;
        for (int k = 0; k < 10; k++) begin @(negedge clk); if (!thr_n) n++; end
        vcmp = 3'b000;
        check(n == 0, "R10 83pct not reached", n, 0);
        rd(2'd3, d); check(d[11] == 0, "R10 no status", d[11], 0);
        @(negedge clk); vcmp = 3'b111; idle(5); vcmp = 3'b000; idle(20);
        check(thr_n == 0, "R5 vlim hold", thr_n, 0);
        rd(2'd3, d); check(d[11] == 1, "R10 83pct status", d[11], 1);
        wr(2'd3, 12'h000); idle(1);
        check(thr_n == 1, "R5 vlim release", thr_n, 1);
        wr(2'd1, 12'h018);
        @(negedge clk); vcmp = 3'b010; idle(3); vcmp = 3'b000; idle(3);
        rd(2'd3, d); check(d[11] == 1, "R10 91pct status", d[11], 1);
        wr(2'd3, 12'h000);
        wr(2'd1, 12'h000);
        @(negedge clk); vcmp = 3'b001; idle(3); vcmp = 3'b000; idle(3);
        rd(2'd3, d); check(d[11] == 1, "R10 100pct status", d[11], 1);
        clear_all();
    endtask

    task automatic t_extend();
        int n;
        wr(2'd0, 12'h001); wr(2'd1, 12'h004);
        pulse_count(0, 1, 40, n); check(n == 39, "R4 extend hold", n, 39);
        wr(2'd1, 12'h044); idle(1);
        check(thr_n == 1, "R4 host clear", thr_n, 1);
        wr(2'd1, 12'h000);
        clear_all();
    endtask

    task automatic t_removal();
        logic [11:0] d;
        wr(2'd0, 12'h0C0);
        @(negedge clk); evt[6] = 1; idle(10);
        rd(2'd3, d); check(d[6] == 1, "R7 adrm set", d[6], 1);
        rd(2'd3, d); check(d[6] == 1, "R7 adrm retrigger", d[6], 1);
        evt[6] = 0; idle(5);
        rd(2'd3, d); check(d[6] == 1, "R7 adrm latched", d[6], 1);
        rd(2'd3, d); check(d[6] == 0, "R7 adrm cleared", d[6], 0);
        @(negedge clk); evt[7] = 1; idle(10);
        rd(2'd3, d); check(d[7] == 1, "R8 btrm set", d[7], 1);
        rd(2'd3, d); check(d[7] == 0, "R8 btrm edge only", d[7], 0);
        evt[7] = 0; idle(5);
        clear_all();
    endtask

    task automatic t_thermal();
        logic [11:0] d;
        wr(2'd0, 12'h400); wr(2'd1, 12'h000);
        @(negedge clk); evt[10] = 1; idle(50); evt[10] = 0; idle(5);
        rd(2'd3, d); check(d[10] == 0, "R9 short under", d[10], 0);
        @(negedge clk); evt[10] = 1; idle(150); evt[10] = 0; idle(5);
        rd(2'd3, d); check(d[10] == 1, "R9 short latched", d[10], 1);
        wr(2'd1, 12'h020);
        @(negedge clk); evt[10] = 1; idle(500); evt[10] = 0; idle(5);
        rd(2'd3, d); check(d[10] == 0, "R9 long under", d[10], 0);
        @(negedge clk); evt[10] = 1; idle(1100); evt[10] = 0; idle(5);
        rd(2'd3, d); check(d[10] == 1, "R9 long latched", d[10], 1);
        wr(2'd1, 12'h000);
        clear_all();
    endtask

    task automatic t_soft();
        logic [11:0] d;
        wr(2'd0, 12'h001); wr(2'd1, 12'h004);
        @(negedge clk); evt[9] = 1; evt[0] = 1; @(negedge clk); evt[9] = 0; evt[0] = 0;
        idle(40);
        check(thr_n == 0, "R12 held before", thr_n, 0);
        @(negedge clk); addr = 2'd1; wdata = 12'h084; wr_en = 1;
        @(negedge clk); wr_en = 0;
        check(thr_n == 1, "R12 release next clock", thr_n, 1);
        rd(2'd3, d); check(d == 0, "R12 status cleared", d, 0);
        idle(3); check(thr_n == 1, "R12 stays released", thr_n, 1);
        wr(2'd1, 12'h000);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(3); rst_n = 1; idle(2);
        t_reset();
        t_width();
        t_deglitch();
        t_enable();
        t_vlim();
        t_extend();
        t_removal();
        t_thermal();
        t_soft();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule